// File: doc/BRIEF.md
# Sideband Request Receiver with Firmware Register Window

This block sits between a sideband receive port and a processor's 32-bit register bus. When enabled, it accepts one request message at a time from the port. It stores the header, the address, the extended security fields and up to two data words in read-only registers. It sets a pending flag and raises an interrupt unless that interrupt is masked.

Firmware reads the held message and programs a reply status and a reply data word. It then writes the reply trigger bit. That write releases the held message. If the request was non-posted, the same write also launches a completion toward the sender, which stays valid until the sender takes it.

A three-state machine sequences the block:
- `ST_IDLE`: waits for a message. Transition `IDLE->HELD` occurs when the access gate is open and `rx_valid` is high.
- `ST_HELD`: a message is held. A trigger write moves to `HELD->REPLY` when the request was non-posted, or to `HELD->IDLE` otherwise.
- `ST_REPLY`: the completion is presented. Transition `REPLY->IDLE` occurs when the sender raises `cpl_ready`.

Register map (byte offsets):

| Offset | Register | Fields |
|--------|----------|--------|
| 0x00 | HDR | opcode [7:0], destination [15:8], source [23:16], byte enables [27:24] |
| 0x04 | ADLO | low address |
| 0x08 | ADHI | long flag [31], high 16 bits [15:0] |
| 0x0C | EXT | present flag [31], root space [19:16], security attribute [15:0] |
| 0x10 | DAT0 | first data word |
| 0x14 | DAT1 | second data word |
| 0x18 | CTRL | pending [31], mask [30], two-word flag [2], kind [1:0] |
| 0x1C | SELF | own port ID [7:0] |
| 0x20 | REPLY | trigger/busy [31], status [2:0] |
| 0x24 | RDATA | reply data |
| 0x28 | ENABLE | access gate [0] |

Top module: `sbrx_endpoint`

## Requirements
- R1: After reset every register reads 0 except SELF, which reads the SELF_ID parameter; rx_ready, irq and cpl_valid are 0.
- R2: A message accepted on a clock edge with rx_valid and rx_ready high is visible in HDR and CTRL from the next cycle. CTRL[31] is 1. CTRL[1:0] holds the kind code: 01 posted, 10 non-posted, 11 completion.
- R3: ADHI[31] holds the address-length flag. When the flag is 0 (16-bit address), ADLO holds only rx_addr[15:0] with its upper half zero, and ADHI[15:0] is zero. When the flag is 1 (48-bit address), ADLO holds bits 31:0 and ADHI[15:0] holds bits 47:32.
- R4: EXT[31] holds the extended-header-present flag. The security attribute and root space fields hold the message values when the flag is 1 and read zero when it is 0.
- R5: DAT0 holds the first data word. DAT1 holds the second word when rx_two is 1 and zero otherwise. CTRL[2] records rx_two.
- R6: irq is 1 exactly while a message is pending and the mask bit CTRL[30] is 0. Changing the mask never changes CTRL[31].
- R7: Writing 1 to REPLY[31] while a message is pending clears CTRL[31] in the next cycle. For a non-posted request, cpl_valid rises in that same next cycle. The completion carries destination = held source ID, source = SELF_ID, status = REPLY[2:0] (000 success, 001 unsupported) and data = RDATA. It stays valid and stable until cpl_ready is seen, and REPLY[31] reads 1 while it is outstanding.
- R8: Releasing a posted or completion-kind message produces no completion, and the block returns to accepting messages.
- R9: While ENABLE[0] is 0, rx_ready is 0 and rx_valid leaves every register unchanged.
- R10: While a message is pending or a completion is outstanding, rx_ready is 0 and a new rx_valid leaves the held registers unchanged.
- R11: A write of REPLY[31] when nothing is pending has no effect: no completion, and no change of state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Receive port message valid |
| rx_ready | output | 1 | Receive port can accept |
| rx_dst | input | 8 | Destination port ID |
| rx_src | input | 8 | Source port ID |
| rx_opc | input | 8 | Opcode |
| rx_be | input | 4 | Byte enables |
| rx_kind | input | 2 | Kind code (01 posted, 10 non-posted, 11 completion) |
| rx_addr_long | input | 1 | 1 = 48-bit address |
| rx_addr | input | 48 | Address |
| rx_eh | input | 1 | Extended header present |
| rx_sai | input | 16 | Security attribute |
| rx_rs | input | 4 | Root space |
| rx_two | input | 1 | Second data word valid |
| rx_data0 | input | 32 | First data word |
| rx_data1 | input | 32 | Second data word |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Message interrupt |
| cpl_valid | output | 1 | Completion valid |
| cpl_ready | input | 1 | Completion taken |
| cpl_dst | output | 8 | Completion destination ID |
| cpl_src | output | 8 | Completion source ID |
| cpl_status | output | 3 | Completion status |
| cpl_data | output | 32 | Completion data |

## Verification
Reads are combinational, so a register value can be checked in the same cycle it is addressed. A message accepted at one rising edge, and a trigger or register write committed at one rising edge, take effect at the outputs after that edge. This covers the held fields, pending, irq, cpl_valid and rx_ready. The bench drives each stimulus at a falling edge, lets exactly one rising edge pass, and samples at the following falling edge. A completion leaves one rising edge after cpl_ready is seen, and is sampled at the falling edge after that. The sweep runs every combination of kind, address length, extension flag and word count, and also covers the mask, the gate, an overwrite attempt and a stray trigger.

// File: rtl/sbrx_pkg.sv
package sbrx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HELD,
        ST_REPLY
    } sbrx_state_e;

    localparam logic [1:0] KIND_POSTED    = 2'b01;
    localparam logic [1:0] KIND_NONPOSTED = 2'b10;
    localparam logic [1:0] KIND_CPL       = 2'b11;

    localparam int WORD_W = 32;
    localparam int LONG_A = 48;
    localparam int SHORT_A = 16;

    localparam int OFS_HDR    = 'h00;
    localparam int OFS_ADLO   = 'h04;
    localparam int OFS_ADHI   = 'h08;
    localparam int OFS_EXT    = 'h0C;
    localparam int OFS_DAT0   = 'h10;
    localparam int OFS_DAT1   = 'h14;
    localparam int OFS_CTRL   = 'h18;
    localparam int OFS_SELF   = 'h1C;
    localparam int OFS_REPLY  = 'h20;
    localparam int OFS_RDATA  = 'h24;
    localparam int OFS_ENABLE = 'h28;

    typedef struct packed {
        logic [7:0]        dst;
        logic [7:0]        src;
        logic [7:0]        opc;
        logic [3:0]        be;
        logic [1:0]        kind;
        logic              addr_long;
        logic [LONG_A-1:0] addr;
        logic              eh;
        logic [15:0]       sai;
        logic [3:0]        rs;
        logic              two;
        logic [WORD_W-1:0] data0;
        logic [WORD_W-1:0] data1;
    } sbrx_msg_t;

endpackage

// File: rtl/sbrx_capture.sv
module sbrx_capture
    import sbrx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  sbrx_msg_t msg_in,
    output sbrx_msg_t msg_q
);

    sbrx_msg_t msg_clean;

    always_comb begin
        msg_clean = msg_in;
        if (!msg_in.addr_long) begin
            msg_clean.addr = {{(LONG_A-SHORT_A){1'b0}}, msg_in.addr[SHORT_A-1:0]};
        end
        if (!msg_in.eh) begin
            msg_clean.sai = '0;
            msg_clean.rs  = '0;
        end
        if (!msg_in.two) begin
            msg_clean.data1 = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg_q <= '0;
        end else if (load) begin
            msg_q <= msg_clean;
        end
    end

endmodule

// File: rtl/sbrx_fsm.sv
module sbrx_fsm
    import sbrx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic rx_valid,
    input  logic reply_req,
    input  logic held_nonposted,
    input  logic cpl_ready,
    output logic rx_ready,
    output logic load,
    output logic pending,
    output logic cpl_valid
);

    sbrx_state_e state_q;
    sbrx_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (enable && rx_valid) state_d = ST_HELD;
            end
            ST_HELD: begin
                if (reply_req) state_d = held_nonposted ? ST_REPLY : ST_IDLE;
            end
            ST_REPLY: begin
                if (cpl_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rx_ready  = 1'b0;
        pending   = 1'b0;
        cpl_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  rx_ready  = enable;
            ST_HELD:  pending   = 1'b1;
            ST_REPLY: cpl_valid = 1'b1;
            default: ;
        endcase
        load = rx_ready && rx_valid;
    end

endmodule

// File: rtl/sbrx_regs.sv
module sbrx_regs
    import sbrx_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter logic [7:0]  SELF_ID = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  sbrx_msg_t         msg_q,
    input  logic              pending,
    input  logic              cpl_valid,
    output logic              enable,
    output logic              mask,
    output logic              reply_req,
    output logic [2:0]        reply_status,
    output logic [WORD_W-1:0] reply_data
);

    logic hit_ctrl, hit_reply, hit_rdata, hit_enable;

    assign hit_ctrl   = reg_we && (reg_addr == ADDR_W'(OFS_CTRL));
    assign hit_reply  = reg_we && (reg_addr == ADDR_W'(OFS_REPLY));
    assign hit_rdata  = reg_we && (reg_addr == ADDR_W'(OFS_RDATA));
    assign hit_enable = reg_we && (reg_addr == ADDR_W'(OFS_ENABLE));

    assign reply_req = hit_reply && reg_wdata[31];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable       <= 1'b0;
            mask         <= 1'b0;
            reply_status <= '0;
            reply_data   <= '0;
        end else begin
            if (hit_enable) enable <= reg_wdata[0];
            if (hit_ctrl)   mask   <= reg_wdata[30];
            if (hit_reply && !cpl_valid) reply_status <= reg_wdata[2:0];
            if (hit_rdata && !cpl_valid) reply_data   <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(OFS_HDR):    reg_rdata = {4'b0, msg_q.be, msg_q.src, msg_q.dst, msg_q.opc};
            ADDR_W'(OFS_ADLO):   reg_rdata = msg_q.addr[WORD_W-1:0];
            ADDR_W'(OFS_ADHI):   reg_rdata = {msg_q.addr_long, 15'b0, msg_q.addr[LONG_A-1:WORD_W]};
            ADDR_W'(OFS_EXT):    reg_rdata = {msg_q.eh, 11'b0, msg_q.rs, msg_q.sai};
            ADDR_W'(OFS_DAT0):   reg_rdata = msg_q.data0;
            ADDR_W'(OFS_DAT1):   reg_rdata = msg_q.data1;
            ADDR_W'(OFS_CTRL):   reg_rdata = {pending, mask, 27'b0, msg_q.two, msg_q.kind};
            ADDR_W'(OFS_SELF):   reg_rdata = {24'b0, SELF_ID};
            ADDR_W'(OFS_REPLY):  reg_rdata = {cpl_valid, 28'b0, reply_status};
            ADDR_W'(OFS_RDATA):  reg_rdata = reply_data;
            ADDR_W'(OFS_ENABLE): reg_rdata = {31'b0, enable};
            default:             reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sbrx_endpoint.sv
module sbrx_endpoint
    import sbrx_pkg::*;
#(
    parameter int         ADDR_W  = 8,
    parameter logic [7:0] SELF_ID = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [7:0]        rx_dst,
    input  logic [7:0]        rx_src,
    input  logic [7:0]        rx_opc,
    input  logic [3:0]        rx_be,
    input  logic [1:0]        rx_kind,
    input  logic              rx_addr_long,
    input  logic [47:0]       rx_addr,
    input  logic              rx_eh,
    input  logic [15:0]       rx_sai,
    input  logic [3:0]        rx_rs,
    input  logic              rx_two,
    input  logic [31:0]       rx_data0,
    input  logic [31:0]       rx_data1,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic [7:0]        cpl_dst,
    output logic [7:0]        cpl_src,
    output logic [2:0]        cpl_status,
    output logic [31:0]       cpl_data
);

    sbrx_msg_t   msg_in;
    sbrx_msg_t   msg_q;
    logic        load;
    logic        pending;
    logic        enable;
    logic        mask;
    logic        reply_req;
    logic        held_nonposted;
    logic [2:0]  reply_status;
    logic [31:0] reply_data;

    always_comb begin
        msg_in.dst       = rx_dst;
        msg_in.src       = rx_src;
        msg_in.opc       = rx_opc;
        msg_in.be        = rx_be;
        msg_in.kind      = rx_kind;
        msg_in.addr_long = rx_addr_long;
        msg_in.addr      = rx_addr;
        msg_in.eh        = rx_eh;
        msg_in.sai       = rx_sai;
        msg_in.rs        = rx_rs;
        msg_in.two       = rx_two;
        msg_in.data0     = rx_data0;
        msg_in.data1     = rx_data1;
    end

    assign held_nonposted = (msg_q.kind == KIND_NONPOSTED);

    sbrx_capture u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .msg_in (msg_in),
        .msg_q  (msg_q)
    );

    sbrx_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable         (enable),
        .rx_valid       (rx_valid),
        .reply_req      (reply_req),
        .held_nonposted (held_nonposted),
        .cpl_ready      (cpl_ready),
        .rx_ready       (rx_ready),
        .load           (load),
        .pending        (pending),
        .cpl_valid      (cpl_valid)
    );

    sbrx_regs #(
        .ADDR_W  (ADDR_W),
        .SELF_ID (SELF_ID)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .msg_q        (msg_q),
        .pending      (pending),
        .cpl_valid    (cpl_valid),
        .enable       (enable),
        .mask         (mask),
        .reply_req    (reply_req),
        .reply_status (reply_status),
        .reply_data   (reply_data)
    );

    assign irq        = pending && !mask;
    assign cpl_dst    = msg_q.src;
    assign cpl_src    = SELF_ID;
    assign cpl_status = reply_status;
    assign cpl_data   = reply_data;

endmodule

// File: rtl/sbrx_checker.sv
module sbrx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic       pending,
    input logic       enable,
    input logic       mask,
    input logic       irq,
    input logic       cpl_valid,
    input logic       cpl_ready,
    input logic [2:0] cpl_status
);

    AST_ACCEPT_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |=> pending); // R2

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> !irq); // R6

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pending); // R6

    AST_CPL_FROM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpl_valid) |-> $past(pending)); // R7

    AST_CPL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_status))); // R7

    AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !rx_ready); // R9

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (pending || cpl_valid) |-> !rx_ready); // R10

endmodule

bind sbrx_endpoint sbrx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .pending    (pending),
    .enable     (enable),
    .mask       (mask),
    .irq        (irq),
    .cpl_valid  (cpl_valid),
    .cpl_ready  (cpl_ready),
    .cpl_status (cpl_status)
);

// File: tb/tb_sbrx_endpoint.sv
module tb_sbrx_endpoint;

    localparam logic [7:0] SELF = 8'h3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  rx_dst = '0, rx_src = '0, rx_opc = '0;
    logic [3:0]  rx_be = '0, rx_rs = '0;
    logic [1:0]  rx_kind = '0;
    logic        rx_addr_long = 1'b0, rx_eh = 1'b0, rx_two = 1'b0;
    logic [47:0] rx_addr = '0;
    logic [15:0] rx_sai = '0;
    logic [31:0] rx_data0 = '0, rx_data1 = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, cpl_valid;
    logic        cpl_ready = 1'b0;
    logic [7:0]  cpl_dst, cpl_src;
    logic [2:0]  cpl_status;
    logic [31:0] cpl_data;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sbrx_endpoint #(.ADDR_W(8), .SELF_ID(SELF)) dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_dst(rx_dst), .rx_src(rx_src), .rx_opc(rx_opc), .rx_be(rx_be),
        .rx_kind(rx_kind), .rx_addr_long(rx_addr_long), .rx_addr(rx_addr),
        .rx_eh(rx_eh), .rx_sai(rx_sai), .rx_rs(rx_rs), .rx_two(rx_two),
        .rx_data0(rx_data0), .rx_data1(rx_data1), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
        .cpl_dst(cpl_dst), .cpl_src(cpl_src), .cpl_status(cpl_status),
        .cpl_data(cpl_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [47:0] addr_of(input int i);
        return {16'(16'hA000 + i), 16'(16'h1234 + i), 16'(16'h5600 + i)};
    endfunction

    task automatic send(input int i, input logic [1:0] kind, input logic al,
                        input logic eh, input logic two);
        @(negedge clk);
        rx_dst = 8'(i * 7 + 3); rx_src = 8'(i * 13 + 5); rx_opc = 8'(i * 3 + 'h40);
        rx_be = 4'(i); rx_kind = kind; rx_addr_long = al; rx_addr = addr_of(i);
        rx_eh = eh; rx_sai = 16'(16'h5A00 + i); rx_rs = 4'(i + 1); rx_two = two;
        rx_data0 = 32'hD000_0000 + 32'(i); rx_data1 = 32'hE000_0000 + 32'(i * 3);
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        for (int a = 0; a <= 'h28; a += 4) begin
            rd(8'(a), v);
            chk("R1 reg", v, (a == 'h1C) ? {24'b0, SELF} : 32'h0);
        end
        chk("R1 rx_ready", {31'b0, rx_ready}, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 cpl_valid", {31'b0, cpl_valid}, 0);

        // R9 gate closed: message ignored
        send(40, 2'b10, 1'b1, 1'b1, 1'b1);
        rd(8'h18, v); chk("R9 ctrl", v, 0);
        rd(8'h00, v); chk("R9 hdr", v, 0);
        wr(8'h28, 32'h1);
        chk("R9 ready after enable", {31'b0, rx_ready}, 1);

        // R11 stray trigger
        wr(8'h20, 32'h8000_0000);
        chk("R11 cpl_valid", {31'b0, cpl_valid}, 0);
        rd(8'h18, v); chk("R11 ctrl", v[31:0] & 32'h8000_0000, 0);
        chk("R11 rx_ready", {31'b0, rx_ready}, 1);

        for (int i = 0; i < 24; i++) begin
            logic [1:0] kind;
            logic al, eh, two, msk;
            logic [47:0] ad;
            logic [2:0] st;
            kind = 2'(1 + i % 3);
            al = 1'(i / 3); eh = 1'(i / 6); two = 1'(i / 12);
            msk = (i % 4 == 3);
            ad = addr_of(i);
            st = 3'(i % 2);
            if (msk) wr(8'h18, 32'h4000_0000);
            send(i, kind, al, eh, two);
            rd(8'h00, v);
            chk("R2 hdr", v, {4'b0, 4'(i), 8'(i * 13 + 5), 8'(i * 7 + 3), 8'(i * 3 + 'h40)});
            rd(8'h18, v);
            chk("R2 ctrl", v, {1'b1, msk, 27'b0, two, kind});
            rd(8'h04, v);
            chk("R3 adlo", v, al ? ad[31:0] : {16'b0, ad[15:0]});
            rd(8'h08, v);
            chk("R3 adhi", v, {al, 15'b0, al ? ad[47:32] : 16'h0});
            rd(8'h0C, v);
            chk("R4 ext", v, {eh, 11'b0, eh ? 4'(i + 1) : 4'h0, eh ? 16'(16'h5A00 + i) : 16'h0});
            rd(8'h10, v);
            chk("R5 dat0", v, 32'hD000_0000 + 32'(i));
            rd(8'h14, v);
            chk("R5 dat1", v, two ? 32'hE000_0000 + 32'(i * 3) : 32'h0);
            chk("R6 irq", {31'b0, irq}, {31'b0, !msk});
            chk("R10 rx_ready held", {31'b0, rx_ready}, 0);
            if (i % 4 == 0) begin
                wr(8'h18, 32'h4000_0000);
                chk("R6 irq masked", {31'b0, irq}, 0);
                rd(8'h18, v); chk("R6 pending kept", {31'b0, v[31]}, 1);
                wr(8'h18, 32'h0);
                chk("R6 irq unmasked", {31'b0, irq}, 1);
            end
            if (i == 5) begin
                send(30, 2'b01, 1'b0, 1'b0, 1'b0);
                rd(8'h00, v);
                chk("R10 hdr kept", v, {4'b0, 4'(i), 8'(i * 13 + 5), 8'(i * 7 + 3), 8'(i * 3 + 'h40)});
            end
            wr(8'h24, 32'hC0DE_0000 + 32'(i));
            wr(8'h20, {1'b1, 28'b0, st});
            rd(8'h18, v); chk("R7 pending cleared", {31'b0, v[31]}, 0);
            chk("R7 irq off", {31'b0, irq}, 0);
            if (kind == 2'b10) begin
                chk("R7 cpl_valid", {31'b0, cpl_valid}, 1);
                chk("R7 cpl_dst", {24'b0, cpl_dst}, {24'b0, 8'(i * 13 + 5)});
                chk("R7 cpl_src", {24'b0, cpl_src}, {24'b0, SELF});
                chk("R7 cpl_status", {29'b0, cpl_status}, {29'b0, st});
                chk("R7 cpl_data", cpl_data, 32'hC0DE_0000 + 32'(i));
                rd(8'h20, v); chk("R7 busy bit", {31'b0, v[31]}, 1);
                chk("R10 rx_ready in reply", {31'b0, rx_ready}, 0);
                @(negedge clk);
                chk("R7 cpl held", {31'b0, cpl_valid}, 1);
                cpl_ready = 1'b1;
                @(negedge clk);
                cpl_ready = 1'b0;
                chk("R7 cpl taken", {31'b0, cpl_valid}, 0);
                rd(8'h20, v); chk("R7 busy clear", {31'b0, v[31]}, 0);
            end else begin
                chk("R8 no cpl", {31'b0, cpl_valid}, 0);
            end
            chk("R8 ready again", {31'b0, rx_ready}, 1);
            if (msk) wr(8'h18, 32'h0);
        end
        finish_run();
    end

endmodule